// File: doc/BRIEF.md
# Noise-Adaptive Block-Histogram Frame Thresholder

This block picks one binarisation threshold per video frame from a streamed difference image. Pixels arrive one per clock, 8 bits wide, with a start-of-frame flag on the first pixel and an end-of-line flag on the last pixel of each line. The frame is cut into `NUM_BLK` vertical strips of `BLK_W` columns. For every strip the block builds a gray-level histogram and a pixel sum. Once the frame has ended it scans each histogram in turn. It splits the 256 gray levels into `NUM_INT` equal intervals, takes the most frequent level in each interval, and adds these peaks together. The strip mean comes from multiplying the pixel sum by a programmed reciprocal of the strip pixel count.

A single accumulator takes the peak sums and means one after the other. Their total is divided by `NUM_BLK*(NUM_INT+1)` to give a global threshold. The block then adds a tenth of an externally estimated noise variance to it. The result is snapped to one of three programmable levels. A temporal rule then compares this level with the level of the previous frame, so a single one-step wobble between frames does not move the output. The final threshold is loaded once per frame. A compare port binarises pixels of a separately buffered frame against it.

Top module: `fth_thresholder`

## Requirements
- R1: After reset, `thr_o` is 0 and `thr_vld_o` is 0.
- R2: A pixel belongs to the strip given by its column divided by `BLK_W`. The column restarts at 0 after each `eol_i` and at a pixel flagged `sof_i`. The frame ends with the `eol_i` pixel of line `NUM_LINES-1`.
- R3: Interval j of a strip covers gray levels j*256/`NUM_INT` up to (j+1)*256/`NUM_INT`-1. Its peak is the level with the highest count. On a tie the lowest such level wins. An empty interval yields its lowest level. A strip's peak sum is the sum of its interval peaks.
- R4: The strip mean is the low 8 bits of (strip pixel sum × `recip_i`) >> 16.
- R5: The global threshold is floor(Σ over strips of (peak sum + mean) / (`NUM_BLK`·`NUM_INT` + `NUM_BLK`)).
- R6: The adapted threshold is the global threshold plus floor(`noise_var_i`·26/256).
- R7: With `lvl_lo_i` ≤ `lvl_mid_i` ≤ `lvl_hi_i`, the quantised level is the largest of the three (index 2, 1 or 0) that does not exceed the adapted value. If the value is below `lvl_lo_i`, index 0 (`lvl_lo_i`) is used.
- R8: The first frame after reset always loads its quantised level. After that, `thr_o` takes the new level only if its index equals the previous frame's index or differs from it by two. When the index differs by exactly one, `thr_o` is held.
- R9: `thr_vld_o` pulses for one cycle per frame, within `NUM_BLK`·256+16 cycles after the last pixel. `thr_o` changes only in a cycle where `thr_vld_o` is high.
- R10: `bin_o` is 1 exactly when `bin_pix_i` is greater than `thr_o`.
- R11: Each frame's result depends only on that frame's pixels: histograms and sums restart at `sof_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pix_valid_i | input | 1 | Pixel strobe |
| pix_i | input | 8 | Difference-image pixel |
| sof_i | input | 1 | First pixel of the frame |
| eol_i | input | 1 | Last pixel of a line |
| recip_i | input | 16 | Reciprocal of the strip pixel count, scaled by 2^16 |
| noise_var_i | input | 16 | Estimated noise variance |
| lvl_lo_i | input | 16 | Lowest quantisation level |
| lvl_mid_i | input | 16 | Middle quantisation level |
| lvl_hi_i | input | 16 | Highest quantisation level |
| bin_pix_i | input | 8 | Pixel to binarise |
| thr_o | output | 16 | Current frame threshold |
| thr_vld_o | output | 1 | One-cycle pulse when a frame's decision is made |
| bin_o | output | 1 | Binary result of comparing `bin_pix_i` with `thr_o` |

## Verification
Interval peak ties are tested with frames that hold exactly equal counts of two levels in one interval. A design that let the later level win would shift the total by a multiple of ten. Uniform frames leave most intervals empty. A design that did not fall back to the interval's lowest level would move the threshold a long way. The three levels are pinned around the modelled adapted value (one below, equal, one above), so an off-by-one anywhere in the mean, the division or the noise term flips the quantised index and shows up at `thr_o`. The temporal rule is driven through a hold on a one-step change, a confirm on the following frame, a two-step jump, and the floor below the lowest level. A design that compared against the held level instead of the previous frame's level would never confirm.

// File: rtl/fth_pkg.sv
package fth_pkg;
  localparam int unsigned PIX_W   = 8;
  localparam int unsigned GRAY_N  = 256;
  localparam int unsigned THR_W   = 16;
  localparam int unsigned ADP_W   = 17;
  localparam int unsigned NZ_MUL  = 26;
  localparam int unsigned NZ_SH   = 8;
  localparam int unsigned MEAN_SH = 16;
  localparam int unsigned TG_SH   = 24;
  typedef logic [1:0] lvl_idx_t;
endpackage

// File: rtl/fth_hist.sv
module fth_hist
  import fth_pkg::*;
#(
  parameter int unsigned BLK_W     = 8,
  parameter int unsigned NUM_BLK   = 4,
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned NUM_INT   = 4,
  localparam int unsigned LAM_W    = $clog2(NUM_INT * 255 + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             sof_i,
  input  logic             eol_i,
  input  logic [15:0]      recip_i,
  output logic             blk_vld_o,
  output logic             blk_last_o,
  output logic [LAM_W-1:0] lam_o,
  output logic [PIX_W-1:0] mean_o
);
  localparam int unsigned BLK_PIX  = BLK_W * NUM_LINES;
  localparam int unsigned CNT_W    = $clog2(BLK_PIX + 1);
  localparam int unsigned SUM_W    = $clog2(BLK_PIX * 255 + 1);
  localparam int unsigned BI_W     = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;
  localparam int unsigned COL_W    = (BLK_W > 1) ? $clog2(BLK_W) : 1;
  localparam int unsigned LN_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int unsigned ADDR_W   = BI_W + PIX_W;
  localparam int unsigned HDEPTH   = NUM_BLK * GRAY_N;
  localparam int unsigned INT_BINS = GRAY_N / NUM_INT;
  localparam logic [PIX_W-1:0] INT_MASK = PIX_W'(INT_BINS - 1);

  // ingest position
  logic [COL_W-1:0] col_q, col_eff;
  logic [BI_W-1:0]  blk_q, blk_eff;
  logic [LN_W-1:0]  ln_q, ln_eff;
  logic             scan_go;

  assign col_eff = sof_i ? '0 : col_q;
  assign blk_eff = sof_i ? '0 : blk_q;
  assign ln_eff  = sof_i ? '0 : ln_q;
  assign scan_go = pix_valid_i && eol_i && (ln_eff == LN_W'(NUM_LINES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      blk_q <= '0;
      ln_q  <= '0;
    end else if (pix_valid_i) begin
      if (eol_i) begin
        col_q <= '0;
        blk_q <= '0;
        ln_q  <= ln_eff + LN_W'(1);
      end else if (col_eff == COL_W'(BLK_W - 1)) begin
        col_q <= '0;
        blk_q <= blk_eff + BI_W'(1);
      end else begin
        col_q <= col_eff + COL_W'(1);
      end
    end
  end

  // histogram RAM: one read-modify-write per pixel, cleared on sof
  logic [CNT_W-1:0]  hist_q [HDEPTH];
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  assign wr_addr = {blk_eff, pix_i};

  always_ff @(posedge clk_i) begin
    if (pix_valid_i) begin
      if (sof_i) begin
        for (int i = 0; i < int'(HDEPTH); i++) hist_q[i] <= '0;
        hist_q[wr_addr] <= CNT_W'(1);
      end else begin
        hist_q[wr_addr] <= hist_q[wr_addr] + CNT_W'(1);
      end
    end
  end

  // per-strip pixel sums
  logic [SUM_W-1:0] sum_q [NUM_BLK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NUM_BLK); i++) sum_q[i] <= '0;
    end else if (pix_valid_i) begin
      if (sof_i) begin
        for (int i = 0; i < int'(NUM_BLK); i++) sum_q[i] <= '0;
        sum_q[0] <= SUM_W'(pix_i);
      end else begin
        sum_q[blk_eff] <= sum_q[blk_eff] + SUM_W'(pix_i);
      end
    end
  end

  // post-frame scan
  logic             sc_act_q;
  logic [BI_W-1:0]  sc_blk_q;
  logic [PIX_W-1:0] sc_bin_q;
  logic [CNT_W-1:0] best_cnt_q, rd_cnt, cur_cnt;
  logic [PIX_W-1:0] best_lvl_q, cur_lvl;
  logic [LAM_W-1:0] lam_q, lam_sum;
  logic             int_first, int_last, take;

  assign rd_addr   = {sc_blk_q, sc_bin_q};
  assign rd_cnt    = hist_q[rd_addr];
  assign int_first = (sc_bin_q & INT_MASK) == '0;
  assign int_last  = (sc_bin_q & INT_MASK) == INT_MASK;
  assign take      = int_first || (rd_cnt > best_cnt_q);
  assign cur_lvl   = take ? sc_bin_q : best_lvl_q;
  assign cur_cnt   = take ? rd_cnt : best_cnt_q;
  assign lam_sum   = lam_q + LAM_W'(cur_lvl);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sc_act_q   <= 1'b0;
      sc_blk_q   <= '0;
      sc_bin_q   <= '0;
      best_cnt_q <= '0;
      best_lvl_q <= '0;
      lam_q      <= '0;
      blk_vld_o  <= 1'b0;
      blk_last_o <= 1'b0;
      lam_o      <= '0;
      mean_o     <= '0;
    end else begin
      blk_vld_o <= 1'b0;
      if (scan_go) begin
        sc_act_q <= 1'b1;
        sc_blk_q <= '0;
        sc_bin_q <= '0;
        lam_q    <= '0;
      end else if (sc_act_q) begin
        best_cnt_q <= cur_cnt;
        best_lvl_q <= cur_lvl;
        sc_bin_q   <= sc_bin_q + PIX_W'(1);
        if (int_last) lam_q <= lam_sum;
        if (sc_bin_q == PIX_W'(GRAY_N - 1)) begin
          blk_vld_o  <= 1'b1;
          blk_last_o <= (sc_blk_q == BI_W'(NUM_BLK - 1));
          lam_o      <= lam_sum;
          mean_o     <= PIX_W'((40'(sum_q[sc_blk_q]) * 40'(recip_i)) >> MEAN_SH);
          lam_q      <= '0;
          if (sc_blk_q == BI_W'(NUM_BLK - 1)) sc_act_q <= 1'b0;
          else sc_blk_q <= sc_blk_q + BI_W'(1);
        end
      end
    end
  end

  // R2
  no_pix_in_scan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |-> !sc_act_q);

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_act_q |-> (rd_cnt <= CNT_W'(BLK_PIX)));
endmodule

// File: rtl/fth_est.sv
module fth_est
  import fth_pkg::*;
#(
  parameter int unsigned NUM_BLK = 4,
  parameter int unsigned NUM_INT = 4,
  parameter int unsigned LAM_W   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             blk_vld_i,
  input  logic             blk_last_i,
  input  logic [LAM_W-1:0] lam_i,
  input  logic [PIX_W-1:0] mean_i,
  input  logic [15:0]      noise_i,
  output logic             adp_vld_o,
  output logic [ADP_W-1:0] adp_o
);
  localparam int unsigned DIV   = NUM_BLK * (NUM_INT + 1);
  localparam int unsigned ACC_W = $clog2(255 * DIV + 1);
  localparam longint unsigned TG_RECIP = ((64'd1 << TG_SH) + 64'(DIV) - 64'd1) / 64'(DIV);

  logic [ACC_W-1:0] acc_q, acc_nxt;
  logic [PIX_W-1:0] mean_q, tg_w;
  logic             ph2_q, last_q, fin_q;
  logic [ADP_W-1:0] nz_term;

  // one shared adder: peak sum first, mean on the following cycle
  assign acc_nxt = acc_q + (blk_vld_i ? ACC_W'(lam_i) : ACC_W'(mean_q));
  assign tg_w    = PIX_W'((64'(acc_q) * 64'(TG_RECIP)) >> TG_SH);
  assign nz_term = ADP_W'((32'(noise_i) * 32'(NZ_MUL)) >> NZ_SH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      mean_q    <= '0;
      ph2_q     <= 1'b0;
      last_q    <= 1'b0;
      fin_q     <= 1'b0;
      adp_vld_o <= 1'b0;
      adp_o     <= '0;
    end else begin
      adp_vld_o <= 1'b0;
      fin_q     <= 1'b0;
      ph2_q     <= 1'b0;
      if (clr_i) begin
        acc_q <= '0;
      end else if (blk_vld_i) begin
        acc_q  <= acc_nxt;
        mean_q <= mean_i;
        last_q <= blk_last_i;
        ph2_q  <= 1'b1;
      end else if (ph2_q) begin
        acc_q <= acc_nxt;
        fin_q <= last_q;
      end else if (fin_q) begin
        adp_vld_o <= 1'b1;
        adp_o     <= ADP_W'(tg_w) + nz_term;
      end
    end
  end

  // R6
  adp_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |=> (adp_o >= ADP_W'(($past(noise_i) * 26) >> 8)));

  // R9
  adp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adp_vld_o |=> !adp_vld_o);
endmodule

// File: rtl/fth_quant.sv
module fth_quant
  import fth_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adp_vld_i,
  input  logic [ADP_W-1:0] adp_i,
  input  logic [THR_W-1:0] lvl_lo_i,
  input  logic [THR_W-1:0] lvl_mid_i,
  input  logic [THR_W-1:0] lvl_hi_i,
  output logic [THR_W-1:0] thr_o,
  output logic             thr_vld_o
);
  lvl_idx_t         idx_w, prev_q;
  logic [THR_W-1:0] sel_w;
  logic             primed_q, accept_w;

  always_comb begin
    if (adp_i >= ADP_W'(lvl_hi_i)) begin
      idx_w = 2'd2;
      sel_w = lvl_hi_i;
    end else if (adp_i >= ADP_W'(lvl_mid_i)) begin
      idx_w = 2'd1;
      sel_w = lvl_mid_i;
    end else begin
      idx_w = 2'd0;
      sel_w = lvl_lo_i;
    end
  end

  // equal index, or a two-step jump, is taken; a one-step move is held
  assign accept_w = (idx_w == prev_q) ||
                    (idx_w == 2'd2 && prev_q == 2'd0) ||
                    (idx_w == 2'd0 && prev_q == 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_o     <= '0;
      thr_vld_o <= 1'b0;
      prev_q    <= '0;
      primed_q  <= 1'b0;
    end else begin
      thr_vld_o <= adp_vld_i;
      if (adp_vld_i) begin
        prev_q   <= idx_w;
        primed_q <= 1'b1;
        if (!primed_q || accept_w) thr_o <= sel_w;
      end
    end
  end

  // R9
  thr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adp_vld_i |=> $stable(thr_o));

  // R7
  thr_is_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adp_vld_i |=> (thr_o == $past(lvl_lo_i) || thr_o == $past(lvl_mid_i) ||
                   thr_o == $past(lvl_hi_i) || $stable(thr_o)));

  // R8
  one_step_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adp_vld_i && primed_q && ((idx_w == 2'd1 && prev_q != 2'd1) ||
                               (prev_q == 2'd1 && idx_w != 2'd1)))
    |=> $stable(thr_o));
endmodule

// File: rtl/fth_thresholder.sv
module fth_thresholder
  import fth_pkg::*;
#(
  parameter int unsigned BLK_W     = 8,
  parameter int unsigned NUM_BLK   = 4,
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned NUM_INT   = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pix_valid_i,
  input  logic [7:0]  pix_i,
  input  logic        sof_i,
  input  logic        eol_i,
  input  logic [15:0] recip_i,
  input  logic [15:0] noise_var_i,
  input  logic [15:0] lvl_lo_i,
  input  logic [15:0] lvl_mid_i,
  input  logic [15:0] lvl_hi_i,
  input  logic [7:0]  bin_pix_i,
  output logic [15:0] thr_o,
  output logic        thr_vld_o,
  output logic        bin_o
);
  localparam int unsigned LAM_W = $clog2(NUM_INT * 255 + 1);

  logic             blk_vld, blk_last, adp_vld;
  logic [LAM_W-1:0] lam;
  logic [PIX_W-1:0] mean;
  logic [ADP_W-1:0] adp;

  fth_hist #(
    .BLK_W(BLK_W), .NUM_BLK(NUM_BLK), .NUM_LINES(NUM_LINES), .NUM_INT(NUM_INT)
  ) u_hist (
    .clk_i, .rst_ni, .pix_valid_i, .pix_i, .sof_i, .eol_i, .recip_i,
    .blk_vld_o(blk_vld), .blk_last_o(blk_last), .lam_o(lam), .mean_o(mean)
  );

  fth_est #(.NUM_BLK(NUM_BLK), .NUM_INT(NUM_INT), .LAM_W(LAM_W)) u_est (
    .clk_i, .rst_ni, .clr_i(pix_valid_i && sof_i),
    .blk_vld_i(blk_vld), .blk_last_i(blk_last), .lam_i(lam), .mean_i(mean),
    .noise_i(noise_var_i), .adp_vld_o(adp_vld), .adp_o(adp)
  );

  fth_quant u_quant (
    .clk_i, .rst_ni, .adp_vld_i(adp_vld), .adp_i(adp),
    .lvl_lo_i, .lvl_mid_i, .lvl_hi_i, .thr_o, .thr_vld_o
  );

  assign bin_o = {8'd0, bin_pix_i} > thr_o;

  // R9
  thr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_vld_o |=> !thr_vld_o);
endmodule

// File: tb/tb_fth_thresholder.sv
`timescale 1ns/1ps
module tb_fth_thresholder;
  localparam int BLK_W = 8, NUM_BLK = 4, NUM_LINES = 8, NUM_INT = 4;
  localparam int FRM_W = BLK_W * NUM_BLK;
  localparam int DIV = NUM_BLK * (NUM_INT + 1);
  localparam int IBINS = 256 / NUM_INT;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0, sof = 1'b0, eol = 1'b0;
  logic [7:0]  pix = '0, bin_pix = '0;
  logic [15:0] recip = 16'd1024, noise = '0, lvl_lo = '0, lvl_mid = '0, lvl_hi = '0;
  logic [15:0] thr;
  logic        thr_vld, bin;

  fth_thresholder #(.BLK_W(BLK_W), .NUM_BLK(NUM_BLK), .NUM_LINES(NUM_LINES),
                    .NUM_INT(NUM_INT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pix_valid_i(pix_valid), .pix_i(pix),
    .sof_i(sof), .eol_i(eol), .recip_i(recip), .noise_var_i(noise),
    .lvl_lo_i(lvl_lo), .lvl_mid_i(lvl_mid), .lvl_hi_i(lvl_hi),
    .bin_pix_i(bin_pix), .thr_o(thr), .thr_vld_o(thr_vld), .bin_o(bin));

  int checks = 0, fails = 0;
  int frm [NUM_LINES][FRM_W];
  int exp_thr = 0, prev_idx = 0;
  bit primed = 0;

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // R3 R4 R5 R6 reference from the requirement text
  function automatic int model_adapt();
    int total = 0;
    for (int k = 0; k < NUM_BLK; k++) begin
      int h [256];
      int sum = 0, lam = 0, mean;
      for (int g = 0; g < 256; g++) h[g] = 0;
      for (int y = 0; y < NUM_LINES; y++)
        for (int x = k * BLK_W; x < (k + 1) * BLK_W; x++) begin
          h[frm[y][x]]++;
          sum += frm[y][x];
        end
      for (int j = 0; j < NUM_INT; j++) begin
        int best = j * IBINS;
        for (int g = j * IBINS + 1; g < (j + 1) * IBINS; g++)
          if (h[g] > h[best]) best = g;
        lam += best;
      end
      mean = ((sum * int'(recip)) >> 16) & 255;
      total += lam + mean;
    end
    return total / DIV + ((int'(noise) * 26) >> 8);
  endfunction

  task automatic fill_const(int v);
    for (int y = 0; y < NUM_LINES; y++)
      for (int x = 0; x < FRM_W; x++) frm[y][x] = v;
  endtask

  task automatic run_frame(string tag);
    int a, idx, lv, n, old;
    bit stable_ok = 1;
    a = model_adapt();
    if (a >= int'(lvl_hi)) begin idx = 2; lv = lvl_hi; end
    else if (a >= int'(lvl_mid)) begin idx = 1; lv = lvl_mid; end
    else begin idx = 0; lv = lvl_lo; end
    if (!primed || idx == prev_idx || idx - prev_idx > 1 || prev_idx - idx > 1)
      exp_thr = lv;
    prev_idx = idx;
    primed = 1;
    old = thr;
    for (int y = 0; y < NUM_LINES; y++)
      for (int x = 0; x < FRM_W; x++) begin
        @(negedge clk);
        pix_valid = 1'b1;
        pix = 8'(frm[y][x]);
        sof = (x == 0 && y == 0);
        eol = (x == FRM_W - 1);
        if (thr !== 16'(old) || thr_vld) stable_ok = 0;
      end
    @(negedge clk);
    pix_valid = 1'b0; sof = 1'b0; eol = 1'b0;
    n = 0;
    while (!thr_vld && n < NUM_BLK * 256 + 16) begin
      if (thr !== 16'(old)) stable_ok = 0;
      @(negedge clk);
      n++;
    end
    chk({"R9 pulse in time ", tag}, int'(thr_vld), 1);
    chk({"R9 held until pulse ", tag}, int'(stable_ok), 1);
    chk(tag, int'(thr), exp_thr);
    @(negedge clk);
    chk({"R9 single pulse ", tag}, int'(thr_vld), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 thr after reset", int'(thr), 0);
    chk("R1 thr_vld after reset", int'(thr_vld), 0);
  endtask

  task automatic t_first();
    lvl_lo = 50; lvl_mid = 100; lvl_hi = 150; noise = 0; recip = 1024;
    fill_const(100);  // R3 empty intervals -> 0+100+128+192, Tg 104
    chk("R5 model sanity", model_adapt(), 104);
    run_frame("R8 first frame loads mid level");
  endtask

  task automatic t_one_step();
    noise = 500;  // R6 +50 -> 154, index 2 vs 1
    run_frame("R8 one-step change held");
  endtask

  task automatic t_confirm();
    run_frame("R8 repeated index taken");
  endtask

  task automatic t_jump();
    noise = 0;
    fill_const(10);  // Tg 80 -> index 0, prev 2
    run_frame("R8 two-step jump taken");
  endtask

  task automatic t_floor();
    lvl_lo = 90;
    run_frame("R7 below lowest floors to lvl_lo");
  endtask

  task automatic pinned(string tag);
    int a = model_adapt();
    lvl_lo = 16'(a - 1); lvl_mid = 16'(a); lvl_hi = 16'(a + 1);
    run_frame(tag);
  endtask

  task automatic t_patterns();
    recip = 1000; noise = 37;
    for (int s = 1; s <= 4; s++) begin
      for (int y = 0; y < NUM_LINES; y++)
        for (int x = 0; x < FRM_W; x++)
          frm[y][x] = (x * s * 13 + y * 7 * s + (x / BLK_W) * 40 + s * 3) % 256;
      pinned("R2 R4 R5 R6 R11 pattern frame");
    end
  endtask

  task automatic t_tie();
    recip = 1024; noise = 3;
    for (int y = 0; y < NUM_LINES; y++)
      for (int x = 0; x < FRM_W; x++) frm[y][x] = ((x + y) % 2) ? 80 : 70;
    pinned("R3 tie picks lowest level");
    for (int y = 0; y < NUM_LINES; y++)
      for (int x = 0; x < FRM_W; x++) frm[y][x] = (x < BLK_W) ? 250 : ((x * 3) % 256);
    pinned("R3 R11 skewed strip");
  endtask

  task automatic t_binarise();
    bin_pix = 8'(exp_thr);
    @(negedge clk);
    chk("R10 equal gives 0", int'(bin), 0);
    bin_pix = 8'(exp_thr + 1);
    @(negedge clk);
    chk("R10 above gives 1", int'(bin), 1);
    bin_pix = 8'(exp_thr - 1);
    @(negedge clk);
    chk("R10 below gives 0", int'(bin), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_first();
    t_one_step();
    t_confirm();
    t_jump();
    t_floor();
    t_patterns();
    t_tie();
    t_binarise();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule